// File: doc/BRIEF.md
# Multiprocessor Interrupt Router

This block gathers the interrupt sources of a small multiprocessor board into one 32-bit status word. The status word holds three kinds of bits:

- seven external bus request lines and six on-board device lines, which follow their inputs;
- four hardware fault events, which are latched;
- two software interrupt bits per processor.

Each of up to four processors has its own 32-bit enable mask. For each processor the block drives one interrupt line. It also drives a 3-bit priority level: the highest of seven fixed source groups that has an enabled bit pending.

Software reaches the block through a simple synchronous bus with a request strobe, a write flag, a byte address and 32-bit data. Read data comes back one cycle after the request. Several registers act only on the bits written as one: setting soft bits, clearing soft bits and clearing fault latches.

Top module: `irq_router`

## Requirements
- R1: After reset all enable masks, soft bits and fault latches are zero, so irq_o, level_o and rdata_o are zero.
- R2: The enable mask of CPU n is read and written at byte offset 0x04 shifted left by n (0x04, 0x08, 0x10, 0x20). A write to 0x3C loads all four masks at once; reading 0x3C returns zero.
- R3: A read at 0x40 returns the status word, and rdata_o carries the value in the cycle after the request. The status word has this bit map:
  - soft bits: low at n, high at n+24;
  - bus requests 1..7: bits 4, 6, 10, 12, 14, 19, 23;
  - device lines 0..5: bits 7, 8, 16, 17, 21, 28;
  - faults: sysfail 20, AC fail 30, abort 31, arbiter timeout 29.
  All other status bits read zero. Unmapped reads return zero, and rdata_o is zero after any cycle without a read.
- R4: Bus request and device bits in the status word equal their inputs as sampled on the previous clock edge.
- R5: A write to 0x80 sets the soft bits written as one. Written ones outside bits 0..3 and 24..27 are ignored.
- R6: A write to 0x84 clears the soft bits written as one and leaves the others unchanged.
- R7: A fault bit is set on a rising edge of its input and held until cleared. Clearing is done by writing one to bit 0 (sysfail), 1 (AC fail), 2 (abort) or 3 (arbiter timeout) at offset 0x8C.
- R8: If a fault rising edge and a clear of the same fault occur in the same cycle, the fault bit is left set.
- R9: irq_o[n] is the OR of the status word ANDed with CPU n's mask, visible in the same cycle as the state it depends on.
- R10: level_o[3n+2:3n] is the highest group holding an enabled pending bit, or 0 if there is none. The groups are:
  - level 7: bits 31, 30, 23, 20;
  - level 6: bit 19;
  - level 5: bits 14, 21, 28;
  - level 4: bit 12;
  - level 3: bits 10, 17;
  - level 2: bit 6;
  - level 1: bit 4.
  Other bits affect irq_o only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset within the block |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after a read |
| bus_irq_i | input | 7 | External bus requests 1..7 (index 0 = request 1) |
| dev_irq_i | input | 6 | On-board device lines |
| fault_i | input | 4 | Fault events: sysfail, AC fail, abort, arbiter timeout |
| irq_o | output | NUM_CPU | Interrupt line per CPU |
| level_o | output | 3*NUM_CPU | Pending priority level per CPU |

## Verification
Random bus traffic is mixed with random source toggles, and every output is compared each cycle with a bench model. This exposes mistakes in bit placement and in register decode. A walk that drives one bus request at a time with all enables set checks each level boundary on its own. Soft bits are raised one CPU at a time while each CPU enables only its own pair, which separates routing errors from masking errors. The fault tests use held, pulsed and clear-while-rising inputs to tell edge latching apart from level following, and to show that set wins over clear.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned N_BUS = 7;
  localparam int unsigned N_DEV = 6;
  localparam int unsigned N_FLT = 4;
  localparam int unsigned LVL_W = 3;
  localparam int unsigned N_LVL = 7;

  localparam logic [7:0] OFF_EN_ALL   = 8'h3C;
  localparam logic [7:0] OFF_STATUS   = 8'h40;
  localparam logic [7:0] OFF_SOFT_SET = 8'h80;
  localparam logic [7:0] OFF_SOFT_CLR = 8'h84;
  localparam logic [7:0] OFF_FLT_CLR  = 8'h8C;

  localparam int SOFT_HI_BASE = 24;

  // fault index = clear bit position
  localparam int FI_SYSFAIL = 0;
  localparam int FI_ACFAIL  = 1;
  localparam int FI_ABORT   = 2;
  localparam int FI_ARBTO   = 3;

  localparam int BUS_POS [N_BUS] = '{4, 6, 10, 12, 14, 19, 23};
  localparam int DEV_POS [N_DEV] = '{7, 8, 16, 17, 21, 28};
  localparam int FLT_POS [N_FLT] = '{20, 30, 31, 29};

  function automatic logic [DW-1:0] bit_at(input int p);
    return DW'(1) << p;
  endfunction

  function automatic logic [DW-1:0] soft_mask(input int ncpu);
    logic [DW-1:0] m;
    m = '0;
    for (int n = 0; n < ncpu; n++) begin
      m = m | bit_at(n) | bit_at(n + SOFT_HI_BASE);
    end
    return m;
  endfunction

  function automatic logic [DW-1:0] level_mask(input int lvl);
    case (lvl)
      7: return bit_at(FLT_POS[FI_ABORT]) | bit_at(FLT_POS[FI_ACFAIL]) |
                bit_at(BUS_POS[6]) | bit_at(FLT_POS[FI_SYSFAIL]);
      6: return bit_at(BUS_POS[5]);
      5: return bit_at(BUS_POS[4]) | bit_at(DEV_POS[5]) | bit_at(DEV_POS[4]);
      4: return bit_at(BUS_POS[3]);
      3: return bit_at(BUS_POS[2]) | bit_at(DEV_POS[3]);
      2: return bit_at(BUS_POS[1]);
      1: return bit_at(BUS_POS[0]);
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] mapped_mask(input int ncpu);
    logic [DW-1:0] m;
    m = soft_mask(ncpu);
    for (int k = 0; k < int'(N_BUS); k++) m = m | bit_at(BUS_POS[k]);
    for (int k = 0; k < int'(N_DEV); k++) m = m | bit_at(DEV_POS[k]);
    for (int k = 0; k < int'(N_FLT); k++) m = m | bit_at(FLT_POS[k]);
    return m;
  endfunction
endpackage

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_BUS-1:0] bus_i,
  input  logic [N_DEV-1:0] dev_i,
  input  logic [N_FLT-1:0] flt_i,
  input  logic             soft_set_i,
  input  logic             soft_clr_i,
  input  logic             flt_clr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    status_o
);
  localparam logic [DW-1:0] SOFT_M = soft_mask(NUM_CPU);

  logic [N_BUS-1:0] bus_q;
  logic [N_DEV-1:0] dev_q;
  logic [N_FLT-1:0] flt_q, flt_prev_q, flt_rise, flt_clr;
  logic [DW-1:0]    soft_q, soft_d;

  assign flt_rise = flt_i & ~flt_prev_q;
  assign flt_clr  = flt_clr_i ? wdata_i[N_FLT-1:0] : '0;

  always_comb begin
    soft_d = soft_q;
    if (soft_set_i) soft_d = soft_d | (wdata_i & SOFT_M);
    if (soft_clr_i) soft_d = soft_d & ~(wdata_i & SOFT_M);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q      <= '0;
      dev_q      <= '0;
      flt_q      <= '0;
      flt_prev_q <= '0;
      soft_q     <= '0;
    end else begin
      bus_q      <= bus_i;
      dev_q      <= dev_i;
      flt_prev_q <= flt_i;
      // rising edge wins over a same-cycle clear
      flt_q      <= (flt_q & ~flt_clr) | flt_rise;
      soft_q     <= soft_d;
    end
  end

  always_comb begin
    status_o = soft_q & SOFT_M;
    for (int k = 0; k < int'(N_BUS); k++) status_o[BUS_POS[k]] = bus_q[k];
    for (int k = 0; k < int'(N_DEV); k++) status_o[DEV_POS[k]] = dev_q[k];
    for (int k = 0; k < int'(N_FLT); k++) status_o[FLT_POS[k]] = flt_q[k];
  end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [NUM_CPU*DW-1:0] en_o,
  output logic [DW-1:0]         rd_val_o
);
  localparam logic [ADDR_W-1:0] A_ALL = ADDR_W'(OFF_EN_ALL);

  logic [NUM_CPU-1:0] hit;

  for (genvar n = 0; n < int'(NUM_CPU); n++) begin : g_cpu
    localparam logic [ADDR_W-1:0] A_OWN = ADDR_W'(4 << n);
    logic [DW-1:0] en_q;

    assign hit[n] = (addr_i == A_OWN);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                en_q <= '0;
      else if (wr_i && (hit[n] || addr_i == A_ALL)) en_q <= wdata_i;
    end

    assign en_o[n*DW +: DW] = en_q;
  end

  always_comb begin
    rd_val_o = '0;
    for (int n = 0; n < int'(NUM_CPU); n++) begin
      if (hit[n]) rd_val_o = en_o[n*DW +: DW];
    end
  end
endmodule

// File: rtl/irq_cpu_encoder.sv
module irq_cpu_encoder
  import irq_router_pkg::*;
(
  input  logic [DW-1:0]    status_i,
  input  logic [DW-1:0]    en_i,
  output logic             irq_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic [DW-1:0] pend;

  assign pend  = status_i & en_i;
  assign irq_o = |pend;

  always_comb begin
    lvl_o = '0;
    for (int l = 1; l <= int'(N_LVL); l++) begin
      if (|(pend & level_mask(l))) lvl_o = LVL_W'(l);
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              rdata_o,
  input  logic [6:0]               bus_irq_i,
  input  logic [5:0]               dev_irq_i,
  input  logic [3:0]               fault_i,
  output logic [NUM_CPU-1:0]       irq_o,
  output logic [NUM_CPU*LVL_W-1:0] level_o
);
  logic                  wr, rd;
  logic [DW-1:0]         status_w, en_rd, rdata_q;
  logic [NUM_CPU*DW-1:0] en_w;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  irq_status_unit #(.NUM_CPU(NUM_CPU)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_i      (bus_irq_i),
    .dev_i      (dev_irq_i),
    .flt_i      (fault_i),
    .soft_set_i (wr && addr_i == ADDR_W'(OFF_SOFT_SET)),
    .soft_clr_i (wr && addr_i == ADDR_W'(OFF_SOFT_CLR)),
    .flt_clr_i  (wr && addr_i == ADDR_W'(OFF_FLT_CLR)),
    .wdata_i    (wdata_i),
    .status_o   (status_w)
  );

  irq_enable_bank #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_en (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .en_o     (en_w),
    .rd_val_o (en_rd)
  );

  for (genvar n = 0; n < int'(NUM_CPU); n++) begin : g_enc
    irq_cpu_encoder u_enc (
      .status_i (status_w),
      .en_i     (en_w[n*DW +: DW]),
      .irq_o    (irq_o[n]),
      .lvl_o    (level_o[n*LVL_W +: LVL_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 rdata_q <= '0;
    else if (!rd)                                rdata_q <= '0;
    else if (addr_i == ADDR_W'(OFF_STATUS))      rdata_q <= status_w;
    else                                         rdata_q <= en_rd;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned ADDR_W  = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_i,
  input logic                     we_i,
  input logic [ADDR_W-1:0]        addr_i,
  input logic [31:0]              wdata_i,
  input logic [3:0]               fault_i,
  input logic [31:0]              status_i,
  input logic [NUM_CPU-1:0]       irq_o,
  input logic [NUM_CPU*LVL_W-1:0] level_o
);
  localparam logic [31:0] SOFT_M = soft_mask(NUM_CPU);
  localparam logic [31:0] RSV_M  = ~mapped_mask(NUM_CPU);

  logic wr;
  assign wr = req_i && we_i;

  assert_reserved_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i & RSV_M) == '0);

  assert_soft_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(OFF_SOFT_SET)) |=>
      ((status_i & $past(wdata_i) & SOFT_M) == ($past(wdata_i) & SOFT_M)));

  assert_soft_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(OFF_SOFT_CLR)) |=>
      ((status_i & $past(wdata_i) & SOFT_M) == '0));

  // R8 also covered: a rise sets the bit even under a same-cycle clear
  assert_fault_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_i[FI_ABORT]) |=> status_i[FLT_POS[FI_ABORT]]);

  assert_fault_rise_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fault_i[FI_SYSFAIL]) && wr && addr_i == ADDR_W'(OFF_FLT_CLR) &&
     wdata_i[FI_SYSFAIL]) |=> status_i[FLT_POS[FI_SYSFAIL]]);

  assert_fault_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[FLT_POS[FI_ABORT]] &&
     !(wr && addr_i == ADDR_W'(OFF_FLT_CLR) && wdata_i[FI_ABORT])) |=>
      status_i[FLT_POS[FI_ABORT]]);

  for (genvar n = 0; n < int'(NUM_CPU); n++) begin : g_cpu
    assert_level_needs_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_o[n*LVL_W +: LVL_W] != '0) |-> irq_o[n]);
  end
endmodule

bind irq_router irq_router_chk #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .fault_i  (fault_i),
  .status_i (status_w),
  .irq_o    (irq_o),
  .level_o  (level_o)
);

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;
  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        req, we;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [6:0]  bus;
  logic [5:0]  dev;
  logic [3:0]  flt;
  logic [3:0]  irq;
  logic [11:0] level;

  always #2.5 clk = ~clk;

  irq_router u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .bus_irq_i(bus), .dev_irq_i(dev),
    .fault_i(flt), .irq_o(irq), .level_o(level)
  );

  int checks = 0, fails = 0;

  // bench model
  logic [31:0] m_en [NCPU];
  logic [31:0] m_soft;
  logic [3:0]  m_flt, m_prev;
  logic [6:0]  m_bus;
  logic [5:0]  m_dev;

  localparam logic [31:0] SOFT = 32'h0F00_000F;
  localparam logic [31:0] LV7 = 32'hC090_0000;
  localparam logic [31:0] LV6 = 32'h0008_0000;
  localparam logic [31:0] LV5 = 32'h1020_4000;
  localparam logic [31:0] LV4 = 32'h0000_1000;
  localparam logic [31:0] LV3 = 32'h0002_0400;
  localparam logic [31:0] LV2 = 32'h0000_0040;
  localparam logic [31:0] LV1 = 32'h0000_0010;

  function automatic logic [31:0] m_status();
    logic [31:0] s;
    s = m_soft & SOFT;
    s[4] = m_bus[0]; s[6] = m_bus[1]; s[10] = m_bus[2]; s[12] = m_bus[3];
    s[14] = m_bus[4]; s[19] = m_bus[5]; s[23] = m_bus[6];
    s[7] = m_dev[0]; s[8] = m_dev[1]; s[16] = m_dev[2]; s[17] = m_dev[3];
    s[21] = m_dev[4]; s[28] = m_dev[5];
    s[20] = m_flt[0]; s[30] = m_flt[1]; s[31] = m_flt[2]; s[29] = m_flt[3];
    return s;
  endfunction

  function automatic logic [2:0] m_level(logic [31:0] p);
    if (|(p & LV7)) return 3'd7;
    if (|(p & LV6)) return 3'd6;
    if (|(p & LV5)) return 3'd5;
    if (|(p & LV4)) return 3'd4;
    if (|(p & LV3)) return 3'd3;
    if (|(p & LV2)) return 3'd2;
    if (|(p & LV1)) return 3'd1;
    return 3'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int n = 0; n < NCPU; n++) m_en[n] = '0;
    m_soft = '0; m_flt = '0; m_prev = '0; m_bus = '0; m_dev = '0;
  endtask

  // one cycle: drive at negedge, model at posedge, compare 1 ns later
  task automatic cyc(logic r, logic w, logic [7:0] a, logic [31:0] d,
                     logic [6:0] b, logic [5:0] v, logic [3:0] f, string tag);
    logic [31:0] exp_rd, st;
    logic [3:0]  fclr;
    req = r; we = w; addr = a; wdata = d; bus = b; dev = v; flt = f;
    @(posedge clk);
    exp_rd = '0;
    if (r && !w) begin
      st = m_status();
      case (a)
        8'h04: exp_rd = m_en[0];
        8'h08: exp_rd = m_en[1];
        8'h10: exp_rd = m_en[2];
        8'h20: exp_rd = m_en[3];
        8'h40: exp_rd = st;
        default: exp_rd = '0;
      endcase
    end
    if (r && w) begin
      for (int n = 0; n < NCPU; n++)
        if (a == 8'(4 << n) || a == 8'h3C) m_en[n] = d;
      if (a == 8'h80) m_soft = m_soft | (d & SOFT);
      if (a == 8'h84) m_soft = m_soft & ~(d & SOFT);
    end
    fclr = (r && w && a == 8'h8C) ? d[3:0] : 4'h0;
    m_flt  = (m_flt & ~fclr) | (f & ~m_prev);
    m_prev = f;
    m_bus = b; m_dev = v;
    #1;
    chk(tag, rdata, exp_rd);
    st = m_status();
    for (int n = 0; n < NCPU; n++) begin
      chk("R9 irq", {31'd0, irq[n]}, {31'd0, |(st & m_en[n])});
      chk("R10 level", {29'd0, level[n*3 +: 3]}, {29'd0, m_level(st & m_en[n])});
    end
    @(negedge clk);
  endtask

  task automatic idle(int k, string tag);
    for (int i = 0; i < k; i++) cyc(0, 0, 8'h00, '0, bus, dev, flt, tag);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
    cyc(1, 1, a, d, bus, dev, flt, tag);
  endtask

  task automatic rd(logic [7:0] a, string tag);
    cyc(1, 0, a, '0, bus, dev, flt, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; req = 0; we = 0; addr = '0; wdata = '0;
    bus = '0; dev = '0; flt = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state visible before release
    chk("R1 irq", {28'd0, irq}, '0);
    chk("R1 level", {20'd0, level}, '0);
    chk("R1 rdata", rdata, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(8'h40, "R1 status");
    rd(8'h04, "R1 en0");
    rd(8'h20, "R1 en3");

    // R2 enables
    wr(8'h04, 32'hA5A5_0001, "R2");
    wr(8'h08, 32'h5A5A_0002, "R2");
    wr(8'h10, 32'h1234_5678, "R2");
    wr(8'h20, 32'h8765_4321, "R2");
    rd(8'h04, "R2 en0"); rd(8'h08, "R2 en1");
    rd(8'h10, "R2 en2"); rd(8'h20, "R2 en3");
    wr(8'h3C, 32'hFFFF_FFFF, "R2");
    rd(8'h3C, "R2 all reads zero");
    for (int n = 0; n < NCPU; n++) rd(8'(4 << n), "R2 all");
    rd(8'h44, "R3 unmapped");

    // R5 / R6 soft bits
    wr(8'h80, 32'hFFFF_FFFF, "R5");
    rd(8'h40, "R5 only soft bits set");
    wr(8'h84, 32'h0500_0005, "R6");
    rd(8'h40, "R6 partial clear");
    wr(8'h84, 32'hFFFF_FFFF, "R6");
    rd(8'h40, "R6 all clear");

    // per-CPU soft routing, each CPU enables only its own pair
    for (int n = 0; n < NCPU; n++)
      wr(8'(4 << n), (32'd1 << n) | (32'd1 << (n + 24)), "R9");
    for (int n = 0; n < NCPU; n++) begin
      wr(8'h80, 32'd1 << n, "R5 low soft");
      wr(8'h84, 32'd1 << n, "R6 low soft");
      wr(8'h80, 32'd1 << (n + 24), "R5 high soft");
      rd(8'h40, "R5 high soft");
      wr(8'h84, 32'hFFFF_FFFF, "R6");
    end

    // R10 level walk over bus requests and device lines
    wr(8'h3C, 32'hFFFF_FFFF, "R10");
    for (int k = 0; k < 7; k++) begin
      bus = 7'(1 << k);
      idle(1, "R4");
      rd(8'h40, "R4 bus follow");
    end
    bus = '0;
    for (int k = 0; k < 6; k++) begin
      dev = 6'(1 << k);
      idle(1, "R4");
      rd(8'h40, "R4 dev follow");
    end
    dev = '0;
    bus = 7'b0000101;  // levels 1 and 3 together
    idle(2, "R10");
    bus = '0;
    idle(1, "R4");

    // R7 faults
    for (int k = 0; k < 4; k++) begin
      flt = 4'(1 << k);
      idle(2, "R7");
      flt = '0;
      idle(1, "R7");
      rd(8'h40, "R7 latched after pulse");
      wr(8'h8C, 32'(~(1 << k)) & 32'hF, "R7 other clears");
      rd(8'h40, "R7 still held");
      wr(8'h8C, 32'(1 << k), "R7 clear");
      rd(8'h40, "R7 cleared");
    end
    flt = 4'hF;
    idle(1, "R7");
    wr(8'h8C, 32'hF, "R7 clear while held");
    rd(8'h40, "R7 no re-set while held");
    flt = '0;
    idle(1, "R7");
    // R8 set and clear in the same cycle
    cyc(1, 1, 8'h8C, 32'hF, bus, dev, 4'hF, "R8");
    rd(8'h40, "R8 set wins");
    flt = '0;
    wr(8'h8C, 32'hF, "R8");
    rd(8'h40, "R8 cleared");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      logic [3:0] f;
      case ($urandom_range(0, 9))
        0: a = 8'h04; 1: a = 8'h08; 2: a = 8'h10; 3: a = 8'h20;
        4: a = 8'h3C; 5: a = 8'h40; 6: a = 8'h80; 7: a = 8'h84;
        8: a = 8'h8C; default: a = 8'($urandom);
      endcase
      d = $urandom;
      if ($urandom_range(0, 3) == 0) d = 32'd1 << $urandom_range(0, 31);
      f = flt;
      if ($urandom_range(0, 7) == 0) f = flt ^ 4'(1 << $urandom_range(0, 3));
      cyc($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a, d,
          ($urandom_range(0, 2) == 0) ? 7'($urandom) : bus,
          ($urandom_range(0, 2) == 0) ? 6'($urandom) : dev, f, "R3 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule